// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a byte-wide data cache for a 16-bit byte address space. It sits between a processor's load/store path and a memory that moves whole 16-byte lines. Each request address is divided into a block tag, a set number and a byte position. Both ways of the addressed set are searched for a valid line whose stored tag matches. On a hit, a read returns the byte in the same cycle, and a write changes the byte in place.

On a miss, the block stalls the processor and picks a victim way. If that victim holds modified data, the block first writes the line back to memory. It then fetches the missing line and installs it. The stalled request is then served through the normal hit path.

Writes never go straight to memory. Each line keeps a valid bit and a modified bit. Each set keeps one recency bit that names the way to replace next.

Top module: `assoc2_wb_cache`

## Requirements
- R1: Address bits [15:8] are the tag, bits [7:4] pick one of 16 sets, and bits [3:0] pick the byte. Within a line, byte k sits at bits [8k+7:8k] of the 128-bit memory data word, so a read returns the byte stored at the exact address requested.
- R2: Two blocks with different tags that map to the same set can both be resident, and each is then served as a hit.
- R3: After reset every line is invalid. No memory request is pending, `cpu_req_ready` is low, and the first access to any address is treated as a miss.
- R4: A read hit raises `cpu_req_ready` in the same cycle as `cpu_req_valid` and drives the byte on `cpu_rsp_rdata` in that cycle. It causes no memory traffic.
- R5: A write hit stores `cpu_req_wdata` into the addressed byte, marks the line modified, and causes no memory traffic.
- R6: On a miss (read or write), the block issues one line read with `mem_req_we`=0 at the line-aligned address (low 4 bits zero). It installs the returned line and then completes the request as a hit. A write miss leaves the line modified.
- R7: When the victim is valid and modified, the block first writes back the whole victim line (`mem_req_we`=1, the victim's own line address, data including every byte written since it was filled), and only then issues the fill. A clean victim is never written back.
- R8: Victim choice: an invalid way is taken first, way 0 before way 1. With both ways valid, the way named by the set's recency bit is taken.
- R9: Every hit and every fill sets the set's recency bit to the way that was not just accessed.
- R10: While a miss is being served, `cpu_req_ready` stays low. Each memory request holds `mem_req_valid`, its address and its direction steady until the cycle in which `mem_ack` is high. With a memory that acks L cycles after a request appears, `cpu_req_ready` rises L+1 cycles after a clean miss is presented, and 2(L+1) cycles after a miss that needs a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present; held until accepted |
| cpu_req_ready | output | 1 | Request accepted at this edge (hit in idle state) |
| cpu_req_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_req_addr | input | 16 | Byte address |
| cpu_req_wdata | input | 8 | Write byte |
| cpu_rsp_rdata | output | 8 | Read byte, valid while cpu_req_valid and cpu_req_ready are high |
| mem_req_valid | output | 1 | Line request to memory pending |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_req_addr | output | 16 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Line data for write-back, byte k at bits [8k+7:8k] |
| mem_ack | input | 1 | Memory completes the pending request this cycle |
| mem_rdata | input | 128 | Fill line data, valid with mem_ack on a fill |

## Verification
Hits are due in the very cycle a request is driven. The bench samples `cpu_req_ready` and `cpu_rsp_rdata` 1 ns after the falling edge at which it drives the request, and expects no stall at all. For misses, the bench memory acks exactly three cycles after a request appears. The bench counts the falling edges until `cpu_req_ready` rises and compares that count with 4 for a clean miss and 8 for a dirty one. The memory model also logs every write-back and fill with its address and data. Each access is followed by exact checks on how many of each occurred, so an extra, missing or misordered transfer is caught at the access that caused it.

// File: rtl/assoc2_wb_cache.sv
module assoc2_wb_cache #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req_valid,
  output logic                       cpu_req_ready,
  input  logic                       cpu_req_we,
  input  logic [ADDR_W-1:0]          cpu_req_addr,
  input  logic [7:0]                 cpu_req_wdata,
  output logic [7:0]                 cpu_rsp_rdata,
  output logic                       mem_req_valid,
  output logic                       mem_req_we,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [(8<<OFF_W)-1:0]      mem_req_wdata,
  input  logic                       mem_ack,
  input  logic [(8<<OFF_W)-1:0]      mem_rdata
);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINE_W = 8 << OFF_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL} state_t;

  state_t            state_q;
  logic [TAG_W-1:0]  tag_q  [2][SETS];
  logic [LINE_W-1:0] dat_q  [2][SETS];
  logic [SETS-1:0]   vld_q  [2];
  logic [SETS-1:0]   dty_q  [2];
  logic [SETS-1:0]   lru_q;
  logic [TAG_W-1:0]  miss_tag_q;
  logic [SET_W-1:0]  miss_set_q;
  logic              vic_q;

  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [OFF_W-1:0]  req_off;
  logic              hit0, hit1, hit, hit_way, victim;

  assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_set = cpu_req_addr[OFF_W +: SET_W];
  assign req_off = cpu_req_addr[OFF_W-1:0];

  assign hit0    = vld_q[0][req_set] && (tag_q[0][req_set] == req_tag);
  assign hit1    = vld_q[1][req_set] && (tag_q[1][req_set] == req_tag);
  assign hit     = hit0 | hit1;
  assign hit_way = hit1;
  assign victim  = !vld_q[0][req_set] ? 1'b0 :
                   !vld_q[1][req_set] ? 1'b1 : lru_q[req_set];

  assign cpu_req_ready = (state_q == ST_IDLE) && hit;
  assign cpu_rsp_rdata = dat_q[hit_way][req_set][{req_off, 3'b000} +: 8];

  assign mem_req_valid = (state_q != ST_IDLE);
  assign mem_req_we    = (state_q == ST_WBACK);
  assign mem_req_addr  = {(state_q == ST_WBACK) ? tag_q[vic_q][miss_set_q] : miss_tag_q,
                          miss_set_q, {OFF_W{1'b0}}};
  assign mem_req_wdata = dat_q[vic_q][miss_set_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vld_q   <= '{default: '0};
      dty_q   <= '{default: '0};
      lru_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_req_valid) begin
          if (hit) begin
            lru_q[req_set] <= ~hit_way;
            if (cpu_req_we) dty_q[hit_way][req_set] <= 1'b1;
          end else begin
            state_q <= (vld_q[victim][req_set] && dty_q[victim][req_set]) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (mem_ack) begin
          dty_q[vic_q][miss_set_q] <= 1'b0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          vld_q[vic_q][miss_set_q] <= 1'b1;
          dty_q[vic_q][miss_set_q] <= 1'b0;
          lru_q[miss_set_q]        <= ~vic_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && cpu_req_valid) begin
      if (hit) begin
        if (cpu_req_we) dat_q[hit_way][req_set][{req_off, 3'b000} +: 8] <= cpu_req_wdata;
      end else begin
        miss_tag_q <= req_tag;
        miss_set_q <= req_set;
        vic_q      <= victim;
      end
    end
    if (state_q == ST_FILL && mem_ack) begin
      dat_q[vic_q][miss_set_q] <= mem_rdata;
      tag_q[vic_q][miss_set_q] <= miss_tag_q;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit0, hit1})); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R10
  AST_FILL_FOLLOWS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && mem_ack) |=> (mem_req_valid && !mem_req_we)); // R7
  AST_WB_OTHER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_addr[ADDR_W-1 -: TAG_W] != miss_tag_q)); // R7
  AST_FILL_ENDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && mem_ack) |=> !mem_req_valid); // R6
endmodule

// File: tb/assoc2_wb_cache_tb_top.sv
`timescale 1ns/1ps
module assoc2_wb_cache_tb_top;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [15:0]  cpu_req_addr = '0;
  logic [7:0]   cpu_req_wdata = '0;
  logic         cpu_req_ready;
  logic [7:0]   cpu_rsp_rdata;
  logic         mem_req_valid, mem_req_we;
  logic [15:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int tests = 0, fails = 0;
  int wb_cnt = 0, fill_cnt = 0, mcnt = 0;
  bit addr_moved = 1'b0;
  logic [15:0]  paddr, last_wb_addr, last_fill_addr;
  logic [127:0] last_wb_line;
  logic [7:0]   mem    [0:65535];
  logic [7:0]   shadow [0:65535];

  always #2.5 clk = ~clk;

  assoc2_wb_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) begin
      mem[i]    = 8'(i[7:0] ^ i[15:8] ^ 8'h5A);
      shadow[i] = mem[i];
    end
  end

  // Line memory: acks LAT cycles after a request appears
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req_valid) begin
        if (mcnt == 0) paddr = mem_req_addr;
        else if (mem_req_addr != paddr) addr_moved = 1'b1;
        mcnt++;
        if (mcnt == LAT) begin
          mcnt = 0;
          mem_ack = 1'b1;
          if (mem_req_we) begin
            wb_cnt++;
            last_wb_addr = mem_req_addr;
            last_wb_line = mem_req_wdata;
            for (int k = 0; k < 16; k++) mem[{mem_req_addr[15:4], 4'(k)}] = mem_req_wdata[8*k +: 8];
          end else begin
            fill_cnt++;
            last_fill_addr = mem_req_addr;
            for (int k = 0; k < 16; k++) mem_rdata[8*k +: 8] = mem[{mem_req_addr[15:4], 4'(k)}];
          end
        end
      end
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input int exp_stall, input int exp_fill, input int exp_wb, input string rq);
    int stall = 0;
    int f0 = fill_cnt;
    int w0 = wb_cnt;
    logic [7:0] got;
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready && stall < 200) begin
      @(negedge clk); #1; stall++;
    end
    got = cpu_rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(stall == exp_stall, rq, "stall cycles", stall, exp_stall);
    chk(fill_cnt - f0 == exp_fill, rq, "fills", fill_cnt - f0, exp_fill);
    chk(wb_cnt - w0 == exp_wb, rq, "write-backs", wb_cnt - w0, exp_wb);
    if (exp_fill > 0) chk(last_fill_addr == {a[15:4], 4'h0}, rq, "fill address", last_fill_addr, {a[15:4], 4'h0});
    if (we) shadow[a] = wd;
    else chk(got == shadow[a], rq, "read byte", got, shadow[a]);
  endtask

  task automatic t_reset();
    chk(cpu_req_ready == 1'b0, "R3", "ready after reset", cpu_req_ready, 0);
    chk(mem_req_valid == 1'b0, "R3", "mem idle after reset", mem_req_valid, 0);
    access(1'b0, 16'h1A35, 8'h00, LAT+1, 1, 0, "R3_R6_R1 cold read miss");
  endtask

  task automatic t_read_hit();
    access(1'b0, 16'h1A30, 8'h00, 0, 0, 0, "R4_R1 hit byte0");
    access(1'b0, 16'h1A3F, 8'h00, 0, 0, 0, "R4_R1 hit byte15");
  endtask

  task automatic t_write_hit();
    access(1'b1, 16'h1A37, 8'hC3, 0, 0, 0, "R5 write hit");
    access(1'b0, 16'h1A37, 8'h00, 0, 0, 0, "R5 read back");
  endtask

  task automatic t_second_way();
    access(1'b0, 16'h2B32, 8'h00, LAT+1, 1, 0, "R8 fill into invalid way");
    access(1'b0, 16'h1A37, 8'h00, 0, 0, 0, "R2 first block still hits");
    access(1'b0, 16'h2B32, 8'h00, 0, 0, 0, "R2 second block hits");
    access(1'b0, 16'h1A37, 8'h00, 0, 0, 0, "R9 touch first block");
  endtask

  task automatic t_lru();
    access(1'b0, 16'h3C31, 8'h00, LAT+1, 1, 0, "R8_R9 evict least recent clean way");
    access(1'b0, 16'h1A37, 8'h00, 0, 0, 0, "R9 recent block kept");
    access(1'b0, 16'h2B32, 8'h00, LAT+1, 1, 0, "R9 evicted block misses again");
  endtask

  task automatic t_dirty_evict();
    access(1'b0, 16'h4D30, 8'h00, 2*(LAT+1), 1, 1, "R7 dirty victim write-back");
    chk(last_wb_addr == 16'h1A30, "R7", "write-back address", last_wb_addr, 16'h1A30);
    chk(last_wb_line[8*7 +: 8] == 8'hC3, "R7", "written byte in line", last_wb_line[8*7 +: 8], 8'hC3);
    chk(last_wb_line[7:0] == shadow[16'h1A30], "R7_R1", "untouched byte in line", last_wb_line[7:0], shadow[16'h1A30]);
    access(1'b0, 16'h1A37, 8'h00, LAT+1, 1, 0, "R7 refetched modified byte");
  endtask

  task automatic t_write_miss();
    access(1'b1, 16'h7754, 8'h9E, LAT+1, 1, 0, "R6 write miss fill");
    access(1'b0, 16'h7754, 8'h00, 0, 0, 0, "R6 write miss stored");
    access(1'b0, 16'h8850, 8'h00, LAT+1, 1, 0, "R8 second way of set 5");
    access(1'b0, 16'h9951, 8'h00, 2*(LAT+1), 1, 1, "R6_R7 write-missed line is dirty");
    chk(last_wb_addr == 16'h7750, "R7", "write-back address set 5", last_wb_addr, 16'h7750);
    chk(last_wb_line[8*4 +: 8] == 8'h9E, "R6", "write-miss byte written back", last_wb_line[8*4 +: 8], 8'h9E);
    chk(addr_moved == 1'b0, "R10", "memory address held while pending", addr_moved, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_second_way();
    t_lru();
    t_dirty_evict();
    t_write_miss();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule